// File: doc/BRIEF.md
# MDIO User-Access Transaction Arbiter

This block holds a small set of host-programmable management access channels. Each channel stores one pending PHY register transaction: a data word, a PHY address, a register address and a direction flag. A go bit marks the channel as pending. Once the host sets go, the block needs no further action from it. The block picks among pending channels in rotating order and offers the chosen one to a shared MDIO frame engine over a request/grant/done handshake. It always gives way while the background link poller is using, or asking for, the engine.

When the engine reports completion, the block writes the result back into the channel. A read returns its data word and an acknowledge flag that shows whether the PHY answered. The block then drops the channel's go bit and latches a per-channel completion interrupt. The host clears that interrupt by writing ones to it. A mask, moved by separate set and clear strobes, gates the raw interrupt onto a masked output.

Top module: `mgmt_xact_arb`

## Requirements
- R1: A host write to a channel whose go bit is clear loads its data, PHY address, register address and write flag, and it loads go from `hst_wr_go`. When go becomes 1, `eng_req` is high in the next cycle with no further host action, unless the poller holds the engine.
- R2: While `eng_req` is high, `eng_write`, `eng_phy`, `eng_reg` and `eng_wdata` carry the fields of the selected channel. After `eng_gnt` is seen with `eng_req`, `eng_req` stays low until `eng_done`, so at most one transaction is outstanding.
- R3: The cycle after `eng_done` ends a transaction, the served channel's `ch_go` bit reads 0.
- R4: The cycle after completion, the served channel's `int_raw` bit reads 1. Writing 1 to an `int_raw_clr` bit clears that raw bit. A completion in the same cycle as the clear takes precedence.
- R5: The channels are served in rotating order. The search starts at a pointer, which is 0 after reset and moves to the channel after the one last granted. The first pending channel found is chosen.
- R6: `eng_req` is low in every cycle in which `poll_active` is high.
- R7: A host write to a channel whose go bit is set changes none of that channel's fields.
- R8: A read completion (write flag 0) loads `eng_rdata` into the channel data and `eng_ack` into `ch_ack`. A write completion (write flag 1) leaves both unchanged. `ch_data` packs channel i at bits [16*i+15:16*i].
- R9: `int_mask_set` bits set mask bits and `int_mask_clr` bits clear them, and the clear wins when both strobe the same bit. `int_masked` equals `int_raw` AND `int_mask`. After reset the mask, raw bits, go, acknowledge and data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr_en | input | 1 | Host write strobe for one channel |
| hst_wr_ch | input | CH_W | Channel written |
| hst_wr_write | input | 1 | Direction flag, 1 = PHY write |
| hst_wr_phy | input | 5 | PHY address |
| hst_wr_reg | input | 5 | PHY register address |
| hst_wr_data | input | 16 | Write data |
| hst_wr_go | input | 1 | Go value loaded with the fields |
| int_raw_clr | input | NUM_CH | Write-1-to-clear of raw completion bits |
| int_mask_set | input | NUM_CH | Write-1 sets mask bits |
| int_mask_clr | input | NUM_CH | Write-1 clears mask bits |
| poll_active | input | 1 | Background poller owns or wants the engine |
| eng_gnt | input | 1 | Engine accepts the offered transaction |
| eng_done | input | 1 | Engine finished the granted transaction |
| eng_rdata | input | 16 | Read data from the engine |
| eng_ack | input | 1 | PHY responded to the read |
| eng_req | output | 1 | User transaction offered to the engine |
| eng_write | output | 1 | Offered direction |
| eng_phy | output | 5 | Offered PHY address |
| eng_reg | output | 5 | Offered register address |
| eng_wdata | output | 16 | Offered write data |
| ch_go | output | NUM_CH | Per-channel go bits |
| ch_ack | output | NUM_CH | Per-channel acknowledge bits |
| ch_data | output | 16*NUM_CH | Per-channel data fields |
| int_raw | output | NUM_CH | Raw completion interrupts |
| int_mask | output | NUM_CH | Interrupt mask |
| int_masked | output | NUM_CH | Masked completion interrupts |

## Verification
Every stored result has a single register between its input and the ports. A host write, a grant, a completion or a mask or clear strobe is driven on a falling edge and shows up after the next rising edge, so the bench checks it on the falling edge that follows. `eng_req` and the offered fields are combinational from state and `poll_active`. Because of that, the poll-yield check is made a moment after `poll_active` changes, in the same cycle, and the one-outstanding check is made one cycle after the grant. The bench acts as the engine, so it knows exactly which cycle a grant or done lands in, and it checks every channel against its own model after each one.

// File: rtl/mxa_pkg.sv
package mxa_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] data;
  } mxa_cmd_t;
endpackage

// File: rtl/mxa_channel.sv
module mxa_channel
  import mxa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  mxa_cmd_t          host_cmd,
  input  logic              host_go,
  input  logic              done_hit,
  input  logic [DATA_W-1:0] rdata,
  input  logic              rack,
  output logic              go,
  output logic              ack,
  output mxa_cmd_t          cmd
);
  // Completion only hits a channel whose go is set, and a host write to such
  // a channel is dropped, so the two branches never compete.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      go  <= 1'b0;
      ack <= 1'b0;
      cmd <= '0;
    end else if (done_hit) begin
      go <= 1'b0;
      if (!cmd.wr) begin
        cmd.data <= rdata;
        ack      <= rack;
      end
    end else if (host_we && !go) begin
      cmd <= host_cmd;
      go  <= host_go;
    end
  end
endmodule

// File: rtl/mxa_rr_sched.sv
module mxa_rr_sched #(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] go_vec,
  input  logic              poll_active,
  input  logic              eng_gnt,
  input  logic              eng_done,
  output logic              eng_req,
  output logic [CH_W-1:0]   sel_ch,
  output logic [CH_W-1:0]   act_ch,
  output logic              busy,
  output logic              xact_start,
  output logic              xact_done
);
  logic [CH_W-1:0] rr_ptr;

  function automatic logic [CH_W-1:0] rr_pick(input logic [NUM_CH-1:0] req,
                                              input logic [CH_W-1:0]   start);
    logic [CH_W-1:0] r;
    logic            found;
    int              idx;
    r     = start;
    found = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      idx = (int'(start) + k) % NUM_CH;
      if (!found && req[idx]) begin
        r     = CH_W'(idx);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [CH_W-1:0] rr_next(input logic [CH_W-1:0] c);
    return (int'(c) == NUM_CH - 1) ? '0 : c + 1'b1;
  endfunction

  assign sel_ch     = rr_pick(go_vec, rr_ptr);
  assign eng_req    = !busy && (|go_vec) && !poll_active;
  assign xact_start = eng_req && eng_gnt;
  assign xact_done  = busy && eng_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      act_ch <= '0;
      rr_ptr <= '0;
    end else if (xact_start) begin
      busy   <= 1'b1;
      act_ch <= sel_ch;
      rr_ptr <= rr_next(sel_ch);
    end else if (xact_done) begin
      busy <= 1'b0;
    end
  end
endmodule

// File: rtl/mxa_irq.sv
module mxa_irq #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] done_vec,
  input  logic [NUM_CH-1:0] raw_clr,
  input  logic [NUM_CH-1:0] mask_set,
  input  logic [NUM_CH-1:0] mask_clr,
  output logic [NUM_CH-1:0] raw,
  output logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] masked
);
  function automatic logic [NUM_CH-1:0] raw_next(input logic [NUM_CH-1:0] cur,
                                                 input logic [NUM_CH-1:0] clr,
                                                 input logic [NUM_CH-1:0] hit);
    return (cur & ~clr) | hit;
  endfunction

  function automatic logic [NUM_CH-1:0] mask_next(input logic [NUM_CH-1:0] cur,
                                                  input logic [NUM_CH-1:0] s,
                                                  input logic [NUM_CH-1:0] c);
    return (cur | s) & ~c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw  <= raw_next(raw, raw_clr, done_vec);
      mask <= mask_next(mask, mask_set, mask_clr);
    end
  end

  assign masked = raw & mask;
endmodule

// File: rtl/mgmt_xact_arb.sv
module mgmt_xact_arb
  import mxa_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hst_wr_en,
  input  logic [CH_W-1:0]          hst_wr_ch,
  input  logic                     hst_wr_write,
  input  logic [ADDR_W-1:0]        hst_wr_phy,
  input  logic [ADDR_W-1:0]        hst_wr_reg,
  input  logic [DATA_W-1:0]        hst_wr_data,
  input  logic                     hst_wr_go,
  input  logic [NUM_CH-1:0]        int_raw_clr,
  input  logic [NUM_CH-1:0]        int_mask_set,
  input  logic [NUM_CH-1:0]        int_mask_clr,
  input  logic                     poll_active,
  input  logic                     eng_gnt,
  input  logic                     eng_done,
  input  logic [DATA_W-1:0]        eng_rdata,
  input  logic                     eng_ack,
  output logic                     eng_req,
  output logic                     eng_write,
  output logic [ADDR_W-1:0]        eng_phy,
  output logic [ADDR_W-1:0]        eng_reg,
  output logic [DATA_W-1:0]        eng_wdata,
  output logic [NUM_CH-1:0]        ch_go,
  output logic [NUM_CH-1:0]        ch_ack,
  output logic [NUM_CH*DATA_W-1:0] ch_data,
  output logic [NUM_CH-1:0]        int_raw,
  output logic [NUM_CH-1:0]        int_mask,
  output logic [NUM_CH-1:0]        int_masked
);
  mxa_cmd_t          cmd [NUM_CH];
  mxa_cmd_t          host_cmd;
  logic [CH_W-1:0]   sel_ch;
  logic [CH_W-1:0]   act_ch;
  logic              busy;
  logic              xact_start;
  logic              xact_done;
  logic [NUM_CH-1:0] done_vec;

  assign host_cmd = '{wr: hst_wr_write, phy: hst_wr_phy, regad: hst_wr_reg, data: hst_wr_data};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign done_vec[i] = xact_done && (int'(act_ch) == i);

    mxa_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_we  (hst_wr_en && (int'(hst_wr_ch) == i)),
      .host_cmd (host_cmd),
      .host_go  (hst_wr_go),
      .done_hit (done_vec[i]),
      .rdata    (eng_rdata),
      .rack     (eng_ack),
      .go       (ch_go[i]),
      .ack      (ch_ack[i]),
      .cmd      (cmd[i])
    );

    assign ch_data[i*DATA_W +: DATA_W] = cmd[i].data;
  end

  mxa_rr_sched #(.NUM_CH(NUM_CH)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_vec      (ch_go),
    .poll_active (poll_active),
    .eng_gnt     (eng_gnt),
    .eng_done    (eng_done),
    .eng_req     (eng_req),
    .sel_ch      (sel_ch),
    .act_ch      (act_ch),
    .busy        (busy),
    .xact_start  (xact_start),
    .xact_done   (xact_done)
  );

  assign eng_write = cmd[sel_ch].wr;
  assign eng_phy   = cmd[sel_ch].phy;
  assign eng_reg   = cmd[sel_ch].regad;
  assign eng_wdata = cmd[sel_ch].data;

  mxa_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_vec (done_vec),
    .raw_clr  (int_raw_clr),
    .mask_set (int_mask_set),
    .mask_clr (int_mask_clr),
    .raw      (int_raw),
    .mask     (int_mask),
    .masked   (int_masked)
  );
endmodule

// File: rtl/mxa_checker.sv
module mxa_checker #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              poll_active,
  input logic              eng_req,
  input logic              busy,
  input logic              xact_done,
  input logic [NUM_CH-1:0] done_vec,
  input logic [NUM_CH-1:0] ch_go,
  input logic [NUM_CH-1:0] int_raw,
  input logic [NUM_CH-1:0] int_mask,
  input logic [NUM_CH-1:0] int_mask_set,
  input logic [NUM_CH-1:0] int_mask_clr
);
  AST_REQ_YIELDS_TO_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    poll_active |-> !eng_req);                                                   // R6
  AST_REQ_NEEDS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> (|ch_go));                                                       // R1
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !eng_req);                                                          // R2
  AST_DONE_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec));                                                         // R5
  AST_GO_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    xact_done |=> ((ch_go & $past(done_vec)) == '0));                            // R3
  AST_RAW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    xact_done |=> ((int_raw & $past(done_vec)) == $past(done_vec)));             // R4
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_mask_set & ~int_mask_clr) != '0) |=>
      ((int_mask & $past(int_mask_set & ~int_mask_clr)) == $past(int_mask_set & ~int_mask_clr))); // R9
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (int_mask_clr != '0) |=> ((int_mask & $past(int_mask_clr)) == '0));          // R9
endmodule

bind mgmt_xact_arb mxa_checker #(.NUM_CH(NUM_CH)) u_mxa_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .poll_active  (poll_active),
  .eng_req      (eng_req),
  .busy         (busy),
  .xact_done    (xact_done),
  .done_vec     (done_vec),
  .ch_go        (ch_go),
  .int_raw      (int_raw),
  .int_mask     (int_mask),
  .int_mask_set (int_mask_set),
  .int_mask_clr (int_mask_clr)
);

// File: tb/mgmt_xact_arb_test.sv
module mgmt_xact_arb_test;
  localparam int N = 2;
  localparam int CW = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hst_wr_en = 0, hst_wr_write = 0, hst_wr_go = 0;
  logic [CW-1:0] hst_wr_ch = '0;
  logic [4:0]    hst_wr_phy = '0, hst_wr_reg = '0;
  logic [15:0]   hst_wr_data = '0;
  logic [N-1:0]  int_raw_clr = '0, int_mask_set = '0, int_mask_clr = '0;
  logic          poll_active = 0, eng_gnt = 0, eng_done = 0, eng_ack = 0;
  logic [15:0]   eng_rdata = '0;
  logic          eng_req, eng_write;
  logic [4:0]    eng_phy, eng_reg;
  logic [15:0]   eng_wdata;
  logic [N-1:0]  ch_go, ch_ack, int_raw, int_mask, int_masked;
  logic [N*16-1:0] ch_data;

  mgmt_xact_arb #(.NUM_CH(N)) uut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic         m_go [N], m_wr [N], m_ack [N];
  logic [4:0]   m_phy [N], m_reg [N];
  logic [15:0]  m_data [N];
  logic [N-1:0] m_raw = '0, m_mask = '0;
  int           m_ptr = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pick_next();
    for (int k = 0; k < N; k++)
      if (m_go[(m_ptr + k) % N]) return (m_ptr + k) % N;
    return -1;
  endfunction

  task automatic check_all();
    for (int i = 0; i < N; i++) begin
      chk("R3 go", 32'(ch_go[i]), 32'(m_go[i]));
      chk("R8 ack", 32'(ch_ack[i]), 32'(m_ack[i]));
      chk("R8 data", 32'(ch_data[i*16 +: 16]), 32'(m_data[i]));
    end
    chk("R4 raw", 32'(int_raw), 32'(m_raw));
    chk("R9 mask", 32'(int_mask), 32'(m_mask));
    chk("R9 masked", 32'(int_masked), 32'(m_raw & m_mask));
  endtask

  task automatic host_wr(input int ch, input logic wr, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] d, input logic go);
    hst_wr_en = 1; hst_wr_ch = CW'(ch); hst_wr_write = wr; hst_wr_phy = phy;
    hst_wr_reg = rg; hst_wr_data = d; hst_wr_go = go;
    @(negedge clk);
    hst_wr_en = 0;
    if (!m_go[ch]) begin
      m_wr[ch] = wr; m_phy[ch] = phy; m_reg[ch] = rg; m_data[ch] = d; m_go[ch] = go;
    end
    check_all();  // R1 load / R7 ignore
  endtask

  task automatic irq_op(input logic [N-1:0] s, input logic [N-1:0] c, input logic [N-1:0] rc);
    int_mask_set = s; int_mask_clr = c; int_raw_clr = rc;
    @(negedge clk);
    int_mask_set = '0; int_mask_clr = '0; int_raw_clr = '0;
    m_raw  = m_raw & ~rc;
    m_mask = (m_mask | s) & ~c;
    check_all();  // R4 clear, R9 set/clear
  endtask

  task automatic serve(input logic [15:0] rd, input logic rack, input logic clr_same);
    int c;
    c = pick_next();
    chk("R1 req", 32'(eng_req), 32'(c >= 0));
    if (c < 0) return;
    chk("R5 rr phy", 32'(eng_phy), 32'(m_phy[c]));
    chk("R2 reg", 32'(eng_reg), 32'(m_reg[c]));
    chk("R2 write", 32'(eng_write), 32'(m_wr[c]));
    chk("R2 wdata", 32'(eng_wdata), 32'(m_data[c]));
    eng_gnt = 1;
    @(negedge clk);
    eng_gnt = 0;
    m_ptr = (c + 1) % N;
    chk("R2 one outstanding", 32'(eng_req), 32'(0));
    repeat ($urandom % 3) @(negedge clk);
    eng_done = 1; eng_rdata = rd; eng_ack = rack;
    if (clr_same) int_raw_clr = '1;
    @(negedge clk);
    eng_done = 0; int_raw_clr = '0;
    if (clr_same) m_raw = '0;
    m_go[c] = 0;
    m_raw[c] = 1'b1;
    if (!m_wr[c]) begin m_data[c] = rd; m_ack[c] = rack; end
    check_all();
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      m_go[i] = 0; m_wr[i] = 0; m_ack[i] = 0; m_phy[i] = '0; m_reg[i] = '0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all();  // R9 reset values
    chk("R1 idle no req", 32'(eng_req), 32'(0));

    // R1: program channel 0 read, request appears the next cycle
    host_wr(0, 1'b0, 5'h02, 5'h01, 16'h0000, 1'b1);
    chk("R1 req after go", 32'(eng_req), 32'(1));
    // R7: rewrite while pending is dropped
    host_wr(0, 1'b1, 5'h1E, 5'h03, 16'hBEEF, 1'b1);
    chk("R7 data kept", 32'(ch_data[15:0]), 32'(0));
    // R6: poller holds engine
    poll_active = 1; #1;
    chk("R6 yield", 32'(eng_req), 32'(0));
    @(negedge clk); @(negedge clk);
    chk("R6 yield held", 32'(eng_req), 32'(0));
    poll_active = 0; #1;
    serve(16'h1234, 1'b1, 1'b0);   // R8 read
    // R8: write leaves data and ack
    host_wr(1, 1'b1, 5'h03, 5'h04, 16'hA5A5, 1'b1);
    serve(16'hFFFF, 1'b0, 1'b0);
    chk("R8 write keeps data", 32'(ch_data[31:16]), 32'h0000A5A5);
    // R5: both pending, pointer now at 0
    host_wr(0, 1'b0, 5'h04, 5'h05, 16'h0, 1'b1);
    host_wr(1, 1'b0, 5'h07, 5'h06, 16'h0, 1'b1);
    serve(16'h1111, 1'b0, 1'b0);
    serve(16'h2222, 1'b1, 1'b1);   // R4 completion beats clear
    // R9 / R4 directed
    irq_op(2'b11, 2'b00, 2'b00);
    irq_op(2'b01, 2'b01, 2'b10);   // clear wins over set
    irq_op(2'b00, 2'b00, 2'b11);

    for (int it = 0; it < 80; it++) begin
      for (int ch = 0; ch < N; ch++)
        if ($urandom % 2)
          host_wr(ch, 1'(($urandom)), {4'($urandom), 1'(ch)}, 5'($urandom), 16'($urandom), 1'b1);
      irq_op(N'($urandom), N'($urandom), N'($urandom));
      if ($urandom % 4 == 0) begin
        poll_active = 1; #1;
        chk("R6 yield random", 32'(eng_req), 32'(0));
        @(negedge clk);
        poll_active = 0; #1;
      end
      while (pick_next() >= 0)
        serve(16'($urandom), 1'($urandom), 1'($urandom % 5 == 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule